// File: doc/BRIEF.md
# Servo Coefficient and State Memory Front End

This block sits between a single register-style access port and the processing engine of a multi-channel servo loop. Every access carries an address, a write-enable flag folded into the top address bit, and a data word. The block decodes the address into one of three targets: a coefficient RAM that holds eight words per profile, a state RAM that holds filter outputs and digitised converter samples, or a single configuration/status register. Reads are answered on a separate response channel after a fixed delay. Writes produce no response.

On its other side the block serves the servo engine. The engine fetches coefficients through a dedicated read port. It reads and writes state through its own ports, and it reports the end of each servo iteration. The configuration register holds the run enable. When software clears the enable, the reported running state stays set until the engine has finished a fixed number of iterations, so software can poll for a clean stop. If the bus and the engine write state in the same cycle, the bus wins, and a saturating counter records the conflict.

Top module: `servo_mem_front`

## Requirements
- R1: After reset `rsp_valid` is 0, `conflict_cnt` is 0, `eng_run` is 0, and a status read returns 2 (bit 0 running = 0, bit 1 stopped = 1).
- R2: Address bit 12 set makes an access a write; clear makes it a read. A read accepted in cycle T raises `rsp_valid` for exactly one cycle, after the second rising edge following T, with `rsp_data` holding the value.
- R3: With address bit 11 clear, bits [10:0] = {channel[2:0], profile[4:0], word[2:0]} address the coefficient RAM. A bus write there is returned by a later bus read of the same address. Within a profile the words are ordered: 0 frequency high half, 1 B1, 2 phase, 3 converter select [2:0] with hold-off [15:8], 4 setpoint, 5 A1, 6 frequency low half, 7 B0.
- R4: The engine coefficient port returns the word at `eng_coef_addr` (same layout as R3) one clock after the address is presented.
- R5: With bit 11 set and bit 10 clear, bits [8:0] address the state RAM. Filter output Y of a channel and profile sits at channel<<5 | profile. Converter sample X0 of input n (0..7) sits at 1<<8 | n<<1. Bus writes are read back by the bus, and by the engine state read port one clock after `eng_st_raddr` is presented.
- R6: An engine state write (`eng_st_we`) with no bus write in that cycle stores `eng_st_wdata` at `eng_st_waddr`.
- R7: When a bus state write and an engine state write fall in the same cycle, only the bus data is stored, the engine write is lost, and `conflict_cnt` increments by one, saturating at all ones.
- R8: Address 0xC00 with bits 11 and 10 set is the configuration register. A write loads the run enable from data bit 0. A read returns running in bit 0, stopped in bit 1 and zero above. Setting the enable sets running and `eng_run` at once.
- R9: After the enable is cleared, running and `eng_run` stay 1 until two `eng_cycle_done` pulses have been seen. Then running reads 0 and stopped reads 1.
- R10: A write access never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe |
| bus_addr | input | 13 | Address, bit 12 = write enable |
| bus_wdata | input | 18 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 18 | Read response data |
| eng_coef_addr | input | 11 | Engine coefficient fetch address |
| eng_coef_data | output | 18 | Engine coefficient data, one cycle later |
| eng_st_raddr | input | 9 | Engine state read address |
| eng_st_rdata | output | 18 | Engine state read data, one cycle later |
| eng_st_we | input | 1 | Engine state write strobe |
| eng_st_waddr | input | 9 | Engine state write address |
| eng_st_wdata | input | 18 | Engine state write data |
| eng_cycle_done | input | 1 | Pulse at the end of a servo iteration |
| eng_run | output | 1 | Engine may run (enabled or still draining) |
| conflict_cnt | output | 8 | Saturating count of lost engine state writes |

## Verification
The assertions check on every cycle that no response appears unless a read was taken two cycles earlier, that write accesses never produce one, that each same-cycle write collision advances the counter, that a set enable always means running, and that draining never ends without an iteration pulse. The bench covers what needs stored contents and whole sequences: sweeps over every coefficient word and every Y and X0 location through both the bus and the engine ports, the loss of the engine's data on a collision, counter saturation, and the exact iteration at which the status flips to stopped.

// File: rtl/svm_pkg.sv
package svm_pkg;

  typedef enum logic [1:0] {
    TGT_COEF  = 2'd0,
    TGT_STATE = 2'd1,
    TGT_CFG   = 2'd2
  } tgt_e;

  function automatic tgt_e decode_tgt(input logic st_sel, input logic cfg_sel);
    if (!st_sel)     return TGT_COEF;
    else if (cfg_sel) return TGT_CFG;
    else             return TGT_STATE;
  endfunction

endpackage

// File: rtl/svm_ram.sv
module svm_ram #(
  parameter int AW = 9,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/svm_ctrl.sv
module svm_ctrl #(
  parameter int DRAIN_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_bit,
  input  logic cycle_done,
  output logic running,
  output logic stopped
);
  localparam int DCW = $clog2(DRAIN_CYCLES + 1);

  logic           cfg_en;
  logic           active;
  logic [DCW-1:0] drain_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en    <= 1'b0;
      active    <= 1'b0;
      drain_cnt <= '0;
    end else if (cfg_wr) begin
      cfg_en    <= cfg_bit;
      drain_cnt <= '0;
      if (cfg_bit) active <= 1'b1;
    end else if (!cfg_en && active && cycle_done) begin
      if (drain_cnt == DCW'(DRAIN_CYCLES - 1)) begin
        active    <= 1'b0;
        drain_cnt <= '0;
      end else begin
        drain_cnt <= drain_cnt + 1'b1;
      end
    end
  end

  assign running = active;
  assign stopped = !cfg_en && !active;

  p_enable_implies_run_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> running);

  p_drain_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (active && !cfg_en && !cycle_done && !cfg_wr) |=> active);
endmodule

// File: rtl/servo_mem_front.sv
module servo_mem_front #(
  parameter int CH_W         = 3,
  parameter int PROF_W       = 5,
  parameter int WORD_W       = 3,
  parameter int DW           = 18,
  parameter int ST_AW        = 9,
  parameter int DRAIN_CYCLES = 2,
  parameter int CNT_W        = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_valid,
  input  logic [CH_W+PROF_W+WORD_W+1:0] bus_addr,
  input  logic [DW-1:0]                 bus_wdata,
  output logic                          rsp_valid,
  output logic [DW-1:0]                 rsp_data,
  input  logic [CH_W+PROF_W+WORD_W-1:0] eng_coef_addr,
  output logic [DW-1:0]                 eng_coef_data,
  input  logic [ST_AW-1:0]              eng_st_raddr,
  output logic [DW-1:0]                 eng_st_rdata,
  input  logic                          eng_st_we,
  input  logic [ST_AW-1:0]              eng_st_waddr,
  input  logic [DW-1:0]                 eng_st_wdata,
  input  logic                          eng_cycle_done,
  output logic                          eng_run,
  output logic [CNT_W-1:0]              conflict_cnt
);
  import svm_pkg::*;

  localparam int CF_AW   = CH_W + PROF_W + WORD_W;
  localparam int AW      = CF_AW + 2;
  localparam int WE_BIT  = AW - 1;
  localparam int ST_BIT  = AW - 2;
  localparam int CFG_BIT = AW - 3;

  tgt_e tgt;
  logic bus_wr, bus_rd, cf_we, bus_st_wr, st_we, cfg_wr;
  logic [ST_AW-1:0] st_waddr;
  logic [DW-1:0]    st_wdata, cf_ra_data, st_ra_data;
  logic running, stopped;

  assign tgt       = decode_tgt(bus_addr[ST_BIT], bus_addr[CFG_BIT]);
  assign bus_wr    = bus_valid && bus_addr[WE_BIT];
  assign bus_rd    = bus_valid && !bus_addr[WE_BIT];
  assign cf_we     = bus_wr && (tgt == TGT_COEF);
  assign bus_st_wr = bus_wr && (tgt == TGT_STATE);
  assign cfg_wr    = bus_wr && (tgt == TGT_CFG);

  // bus has priority on the single state write port
  assign st_we    = bus_st_wr || eng_st_we;
  assign st_waddr = bus_st_wr ? bus_addr[ST_AW-1:0] : eng_st_waddr;
  assign st_wdata = bus_st_wr ? bus_wdata : eng_st_wdata;

  svm_ram #(.AW(CF_AW), .DW(DW)) i_coef_ram (
    .clk     (clk),
    .we      (cf_we),
    .waddr   (bus_addr[CF_AW-1:0]),
    .wdata   (bus_wdata),
    .ra_addr (bus_addr[CF_AW-1:0]),
    .ra_data (cf_ra_data),
    .rb_addr (eng_coef_addr),
    .rb_data (eng_coef_data)
  );

  svm_ram #(.AW(ST_AW), .DW(DW)) i_state_ram (
    .clk     (clk),
    .we      (st_we),
    .waddr   (st_waddr),
    .wdata   (st_wdata),
    .ra_addr (bus_addr[ST_AW-1:0]),
    .ra_data (st_ra_data),
    .rb_addr (eng_st_raddr),
    .rb_data (eng_st_rdata)
  );

  svm_ctrl #(.DRAIN_CYCLES(DRAIN_CYCLES)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_bit    (bus_wdata[0]),
    .cycle_done (eng_cycle_done),
    .running    (running),
    .stopped    (stopped)
  );

  assign eng_run = running;

  // two-stage read response pipeline
  logic       s1_rd;
  tgt_e       s1_tgt;
  logic [1:0] s1_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rd     <= 1'b0;
      s1_tgt    <= TGT_COEF;
      s1_stat   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      s1_rd     <= bus_rd;
      s1_tgt    <= tgt;
      s1_stat   <= {stopped, running};
      rsp_valid <= s1_rd;
      if (s1_rd) begin
        case (s1_tgt)
          TGT_COEF:  rsp_data <= cf_ra_data;
          TGT_STATE: rsp_data <= st_ra_data;
          default:   rsp_data <= DW'(s1_stat);
        endcase
      end else begin
        rsp_data <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) conflict_cnt <= '0;
    else if (bus_st_wr && eng_st_we && (conflict_cnt != {CNT_W{1'b1}}))
      conflict_cnt <= conflict_cnt + 1'b1;
  end

  p_rsp_latency_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(bus_rd, 2));

  p_write_no_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> ##1 !rsp_valid);

  p_conflict_count_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_st_wr && eng_st_we && (conflict_cnt != {CNT_W{1'b1}}))
      |=> conflict_cnt == $past(conflict_cnt) + 1'b1);
endmodule

// File: tb/test_servo_mem_front.sv
module test_servo_mem_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [17:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [17:0] rsp_data;
  logic [10:0] eng_coef_addr = '0;
  logic [17:0] eng_coef_data;
  logic [8:0]  eng_st_raddr = '0;
  logic [17:0] eng_st_rdata;
  logic        eng_st_we = 1'b0;
  logic [8:0]  eng_st_waddr = '0;
  logic [17:0] eng_st_wdata = '0;
  logic        eng_cycle_done = 1'b0;
  logic        eng_run;
  logic [7:0]  conflict_cnt;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  servo_mem_front i_servo_mem_front (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .eng_coef_addr(eng_coef_addr), .eng_coef_data(eng_coef_data),
    .eng_st_raddr(eng_st_raddr), .eng_st_rdata(eng_st_rdata),
    .eng_st_we(eng_st_we), .eng_st_waddr(eng_st_waddr),
    .eng_st_wdata(eng_st_wdata), .eng_cycle_done(eng_cycle_done),
    .eng_run(eng_run), .conflict_cnt(conflict_cnt)
  );

  function automatic logic [17:0] cf_pat(input int a);
    return 18'((a * 1237 + 91) & 18'h3ffff);
  endfunction
  function automatic logic [17:0] st_pat(input int a);
    return 18'((a * 2749 + 3) & 18'h3ffff);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [17:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a | 13'h1000; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, input string req, input logic [17:0] exp);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a & 13'h0fff;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R2 early", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R2 valid", 32'(rsp_valid), 32'd1);
    chk(req, 32'(rsp_data), 32'(exp));
  endtask

  task automatic cycle_pulse();
    @(negedge clk); eng_cycle_done = 1'b1;
    @(negedge clk); eng_cycle_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 conflict_cnt", 32'(conflict_cnt), 0);
    chk("R1 eng_run", 32'(eng_run), 0);
    bus_read(13'h0C00, "R1 status", 18'd2);

    // R3 coefficient sweep through the bus, word order {ch,prof,word}
    for (int a = 0; a < 2048; a++) bus_write(13'(a), cf_pat(a));
    for (int ch = 0; ch < 8; ch++)
      for (int pr = 0; pr < 32; pr++)
        for (int w = 0; w < 8; w++)
          bus_read(13'((ch << 8) | (pr << 3) | w), "R3 coef", cf_pat((ch << 8) | (pr << 3) | w));
    // R4 engine coefficient port, one cycle latency
    for (int a = 0; a < 2048; a++) begin
      @(negedge clk); eng_coef_addr = 11'(a);
      @(negedge clk);
      chk("R4 eng coef", 32'(eng_coef_data), 32'(cf_pat(a)));
    end

    // R5 state: Y locations and X0 locations
    for (int ch = 0; ch < 8; ch++)
      for (int pr = 0; pr < 32; pr++)
        bus_write(13'(13'h800 | (ch << 5) | pr), st_pat((ch << 5) | pr));
    for (int n = 0; n < 8; n++)
      bus_write(13'(13'h800 | 13'h100 | (n << 1)), st_pat(256 | (n << 1)));
    for (int ch = 0; ch < 8; ch++)
      for (int pr = 0; pr < 32; pr++)
        bus_read(13'(13'h800 | (ch << 5) | pr), "R5 Y", st_pat((ch << 5) | pr));
    for (int n = 0; n < 8; n++) begin
      bus_read(13'(13'h900 | (n << 1)), "R5 X0", st_pat(256 | (n << 1)));
      @(negedge clk); eng_st_raddr = 9'(256 | (n << 1));
      @(negedge clk);
      chk("R5 eng X0", 32'(eng_st_rdata), 32'(st_pat(256 | (n << 1))));
    end

    // R10 write gives no response
    bus_write(13'h805, 18'h1234);
    chk("R10 no rsp", 32'(rsp_valid), 0);
    @(negedge clk);
    chk("R10 no rsp", 32'(rsp_valid), 0);

    // R6 engine write alone
    @(negedge clk);
    eng_st_we = 1'b1; eng_st_waddr = 9'h0A3; eng_st_wdata = 18'h2BEEF;
    @(negedge clk); eng_st_we = 1'b0;
    bus_read(13'h8A3, "R6 eng write", 18'h2BEEF);
    chk("R7 no conflict", 32'(conflict_cnt), 0);

    // R7 collision: bus wins, engine lost
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 13'h1810; bus_wdata = 18'h11111;
    eng_st_we = 1'b1; eng_st_waddr = 9'h011; eng_st_wdata = 18'h22222;
    @(negedge clk);
    bus_valid = 1'b0; eng_st_we = 1'b0;
    chk("R7 count one", 32'(conflict_cnt), 1);
    bus_read(13'h810, "R7 bus data", 18'h11111);
    bus_read(13'h811, "R7 engine lost", st_pat(17));
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 13'h1812; bus_wdata = 18'h3;
    eng_st_we = 1'b1; eng_st_waddr = 9'h013; eng_st_wdata = 18'h4;
    repeat (300) @(negedge clk);
    bus_valid = 1'b0; eng_st_we = 1'b0;
    chk("R7 saturate", 32'(conflict_cnt), 255);

    // R8 enable, R9 drain over two iteration pulses
    bus_write(13'h0C00, 18'h1);
    chk("R8 eng_run", 32'(eng_run), 1);
    bus_read(13'h0C00, "R8 status on", 18'd1);
    cycle_pulse();
    bus_read(13'h0C00, "R8 pulse while on", 18'd1);
    bus_write(13'h0C00, 18'h0);
    bus_read(13'h0C00, "R9 draining", 18'd1);
    cycle_pulse();
    chk("R9 run after one", 32'(eng_run), 1);
    bus_read(13'h0C00, "R9 after one", 18'd1);
    cycle_pulse();
    chk("R9 run after two", 32'(eng_run), 0);
    bus_read(13'h0C00, "R9 stopped", 18'd2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule